// File: doc/BRIEF.md
# Protected Glitch-Free Clock Prescaler

This block turns a fast, undivided source clock into the system clock by dividing it by a power of two between 1 and 256. Software picks the ratio through one 8-bit prescale register. The register holds a change-enable bit and a 4-bit division code. The code can only be changed through a two-write sequence. The first write arms the change-enable bit. The second write, which must land within a short window counted in system-clock edges, supplies the new code.

Ratio changes never produce a runt pulse. The system clock is a gated copy of the source clock, and the gate is only opened on counter boundaries. A new ratio is adopted one old period after the write, so the transition is fully predictable. The divided clock can also be routed to a pin, replacing that pin's normal data. The divided clock keeps running while reset is held, so that pin also carries a clock during reset.

Top module: `sysclk_prescaler`

## Requirements
- R1: Register writes are taken only at rising edges of `sys_clk`. The change-enable bit (bit 7 of `rd_data`) becomes 1 only after a write of exactly 0x80, meaning bit 7 is one and bits 6..0 are zero. Any other value leaves the bit as it was.
- R2: The division code (bits 3..0) changes only through a write that has bit 7 at zero and arrives while change-enable is set. A write arriving while change-enable is clear has no effect, and so does a write with bit 7 set that is not 0x80.
- R3: Number the system edges after the arming edge 1, 2, 3 and so on. A code write is accepted at edges 1 to 4 and rejected at edge 5. Change-enable still reads 1 after edge 3, reads 0 after edge 4, and reads 0 right after an accepted code write.
- R4: Writing 0x80 again while the window is open does not clear change-enable and does not restart the window.
- R5: A code N from 0 to 8 gives 2^N source cycles between rising edges of `sys_clk`. Codes 9 to 15 give divide-by-1. Bits 3..0 of `rd_data` read back the last code written.
- R6: Let E0 be the edge that takes a code write. The interval from E0 to E1 is the old period and the interval from E1 to E2 is the new period. No interval is shorter than the smaller of the two periods.
- R7: While `rst_n` is low, `rd_data` is 0x03 and the division is 8 when `boot_div8` is high. Otherwise `rd_data` is 0x00 and the division is 1. `sys_clk` keeps toggling during reset.
- R8: With `clkout_en` high, `pin_out` carries `sys_clk`, including during reset. With `clkout_en` low, `pin_out` equals `gpio_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Undivided source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_div8 | input | 1 | Selects divide-by-8 as the reset default |
| clkout_en | input | 1 | Static enable for driving the clock onto the pin |
| gpio_out | input | 1 | Normal pin data when the clock is not routed |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| sys_clk | output | 1 | Divided system clock |
| pin_out | output | 1 | Shared pin: clock or normal data |
| rd_data | output | 8 | Register readback: change-enable and code |

## Verification
The bench builds the block with its default parameters: an 8-bit register, a four-edge unlock window and a largest exponent of 8. With these values the divide-by-256 extreme, the reserved codes 9 to 15 and both sides of the window boundary all fall inside short runs. Transitions are measured in source cycles between system edges, in both directions: fast to slow, and 256 straight down to 1. These measurements check the one-old-then-new-period rule exactly.

// File: rtl/sysclk_ps_pkg.sv
package sysclk_ps_pkg;
    parameter int REG_W    = 8;
    parameter int CE_POS   = 7;
    parameter int SEL_W    = 4;
    parameter int MAX_LOG  = 8;
    parameter int WINDOW   = 4;
    parameter int BOOT_SEL = 3;
endpackage

// File: rtl/sysclk_ps_unlock.sv
module sysclk_ps_unlock #(
    parameter int REG_W    = sysclk_ps_pkg::REG_W,
    parameter int CE_POS   = sysclk_ps_pkg::CE_POS,
    parameter int SEL_W    = sysclk_ps_pkg::SEL_W,
    parameter int WINDOW   = sysclk_ps_pkg::WINDOW,
    parameter int BOOT_SEL = sysclk_ps_pkg::BOOT_SEL
) (
    input  logic             src_clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             boot_div8_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic [SEL_W-1:0] act_sel_o
);
    localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [REG_W-1:0] ARM_VAL = REG_W'(1) << CE_POS;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);

    typedef struct packed {
        logic             ce;
        logic [WIN_W-1:0] win;
        logic [SEL_W-1:0] prog_sel;
        logic [SEL_W-1:0] act_sel;
    } unlock_t;

    unlock_t st_d, st_q;
    logic    arm_wr, code_wr;

    always_comb begin
        st_d    = st_q;
        arm_wr  = wr_en_i && (wr_data_i == ARM_VAL);
        code_wr = wr_en_i && st_q.ce && !wr_data_i[CE_POS];
        if (tick_i) begin
            // the active code trails the programmed one by one system edge
            st_d.act_sel = st_q.prog_sel;
            if (st_q.ce) begin
                if (st_q.win == WIN_LAST) begin
                    st_d.ce  = 1'b0;
                    st_d.win = '0;
                end else begin
                    st_d.win = st_q.win + WIN_W'(1);
                end
            end
            if (arm_wr && !st_q.ce) begin
                st_d.ce  = 1'b1;
                st_d.win = '0;
            end else if (code_wr) begin
                st_d.prog_sel = wr_data_i[SEL_W-1:0];
                st_d.ce       = 1'b0;
                st_d.win      = '0;
            end
        end
        if (!rst_n) begin
            st_d.ce       = 1'b0;
            st_d.win      = '0;
            st_d.prog_sel = boot_div8_i ? SEL_W'(BOOT_SEL) : '0;
            st_d.act_sel  = boot_div8_i ? SEL_W'(BOOT_SEL) : '0;
        end
    end

    always_ff @(posedge src_clk) begin
        st_q <= st_d;
    end

    always_comb begin
        rd_data_o                = '0;
        rd_data_o[CE_POS]        = st_q.ce;
        rd_data_o[SEL_W-1:0]     = st_q.prog_sel;
        act_sel_o                = st_q.act_sel;
    end

    // R1
    ce_arm_src_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
        $rose(st_q.ce) |-> $past(tick_i && wr_en_i && (wr_data_i == ARM_VAL)));

    // R2
    sel_locked_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
        (tick_i && !st_q.ce) |=> (st_q.prog_sel == $past(st_q.prog_sel)));

    // R3
    win_expire_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
        (tick_i && st_q.ce && (st_q.win == WIN_LAST)) |=> !st_q.ce);

    // R4
    rearm_noext_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
        (tick_i && st_q.ce && arm_wr && (st_q.win != WIN_LAST))
        |=> (st_q.ce && (st_q.win == $past(st_q.win) + WIN_W'(1))));
endmodule

// File: rtl/sysclk_ps_divider.sv
module sysclk_ps_divider #(
    parameter int SEL_W   = sysclk_ps_pkg::SEL_W,
    parameter int MAX_LOG = sysclk_ps_pkg::MAX_LOG
) (
    input  logic             src_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] act_sel_i,
    output logic             tick_o,
    output logic             sys_clk_o
);
    localparam int CNT_W = (MAX_LOG > 0) ? MAX_LOG : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t             dv_d, dv_q;
    logic [CNT_W-1:0] lim;
    logic             tick;
    logic             gate_q;

    function automatic logic [CNT_W-1:0] code_to_lim(input logic [SEL_W-1:0] code);
        logic [CNT_W:0] one_hot;
        if (int'(code) > MAX_LOG) begin
            return '0;
        end
        one_hot = (CNT_W+1)'(1) << code;
        return CNT_W'(one_hot - (CNT_W+1)'(1));
    endfunction

    always_comb begin
        lim      = code_to_lim(act_sel_i);
        tick     = (dv_q.cnt >= lim);
        dv_d     = dv_q;
        dv_d.cnt = tick ? '0 : dv_q.cnt + CNT_W'(1);
    end

    // free-running on purpose: the clock must keep running through reset
    always_ff @(posedge src_clk) begin
        dv_q <= dv_d;
    end

    // gate enable moves only while the source clock is low
    always_ff @(negedge src_clk) begin
        gate_q <= tick;
    end

    assign tick_o    = tick;
    assign sys_clk_o = src_clk & gate_q;

    // R5, R6
    span_after_edge_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
        tick |=> (tick == (lim == '0)));
endmodule

// File: rtl/sysclk_ps_pinmux.sv
module sysclk_ps_pinmux (
    input  logic clk_i,
    input  logic gpio_i,
    input  logic en_i,
    output logic pin_o
);
    always_comb begin
        pin_o = en_i ? clk_i : gpio_i;
    end
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler #(
    parameter int REG_W    = sysclk_ps_pkg::REG_W,
    parameter int CE_POS   = sysclk_ps_pkg::CE_POS,
    parameter int SEL_W    = sysclk_ps_pkg::SEL_W,
    parameter int MAX_LOG  = sysclk_ps_pkg::MAX_LOG,
    parameter int WINDOW   = sysclk_ps_pkg::WINDOW,
    parameter int BOOT_SEL = sysclk_ps_pkg::BOOT_SEL
) (
    input  logic             src_clk,
    input  logic             rst_n,
    input  logic             boot_div8,
    input  logic             clkout_en,
    input  logic             gpio_out,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             sys_clk,
    output logic             pin_out,
    output logic [REG_W-1:0] rd_data
);
    logic             tick;
    logic [SEL_W-1:0] act_sel;

    sysclk_ps_unlock #(
        .REG_W(REG_W), .CE_POS(CE_POS), .SEL_W(SEL_W),
        .WINDOW(WINDOW), .BOOT_SEL(BOOT_SEL)
    ) u_unlock (
        .src_clk    (src_clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .boot_div8_i(boot_div8),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .rd_data_o  (rd_data),
        .act_sel_o  (act_sel)
    );

    sysclk_ps_divider #(
        .SEL_W(SEL_W), .MAX_LOG(MAX_LOG)
    ) u_div (
        .src_clk  (src_clk),
        .rst_n    (rst_n),
        .act_sel_i(act_sel),
        .tick_o   (tick),
        .sys_clk_o(sys_clk)
    );

    sysclk_ps_pinmux u_pin (
        .clk_i (sys_clk),
        .gpio_i(gpio_out),
        .en_i  (clkout_en),
        .pin_o (pin_out)
    );
endmodule

// File: tb/sysclk_prescaler_tb.sv
`timescale 1ns/1ps
module sysclk_prescaler_tb;
    logic       src_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_div8 = 1'b0;
    logic       clkout_en = 1'b0;
    logic       gpio_out = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       sys_clk, pin_out;
    logic [7:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int wd = 0;

    sysclk_prescaler u_dut (
        .src_clk(src_clk), .rst_n(rst_n), .boot_div8(boot_div8),
        .clkout_en(clkout_en), .gpio_out(gpio_out), .wr_en(wr_en),
        .wr_data(wr_data), .sys_clk(sys_clk), .pin_out(pin_out),
        .rd_data(rd_data)
    );

    always #2.5 src_clk = ~src_clk;
    always @(negedge src_clk) cyc++;

    always @(posedge src_clk) begin
        wd++;
        if (wd > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: act=%0d exp<150000", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic sync_edge();
        @(posedge sys_clk);
        #1;
    endtask

    // drive now, taken at the next system edge; t0 = that edge's cycle
    task automatic do_wr(input logic [7:0] d, output int t0);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge sys_clk);
        t0 = cyc;
        #1;
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic next_edge(output int t);
        @(posedge sys_clk);
        t = cyc;
        #1;
    endtask

    task automatic period(output int p);
        int a, b;
        next_edge(a);
        next_edge(b);
        p = b - a;
    endtask

    task automatic set_code(input logic [7:0] code);
        int t;
        sync_edge();
        do_wr(8'h80, t);
        do_wr(code, t);
    endtask

    task automatic t_reset();
        int p, a, b;
        rst_n = 1'b0;
        clkout_en = 1'b1;
        boot_div8 = 1'b1;
        repeat (40) @(posedge src_clk);
        #1;
        chk("R7 boot8 readback", rd_data, 8'h03);
        period(p);
        chk("R7 div8 during reset", p, 8);
        @(posedge pin_out); a = cyc;
        @(posedge pin_out); b = cyc;
        chk("R8 pin clock in reset", b - a, 8);
        boot_div8 = 1'b0;
        repeat (40) @(posedge src_clk);
        #1;
        chk("R7 boot1 readback", rd_data, 8'h00);
        period(p);
        chk("R7 div1 during reset", p, 1);
        rst_n = 1'b1;
        sync_edge();
    endtask

    task automatic t_switch(input logic [7:0] code, input int t_old, input int t_new);
        int t0, t1, t2, t3;
        sync_edge();
        do_wr(8'h80, t0);
        chk("R1 armed", rd_data[7], 1);
        do_wr(code, t0);
        chk("R5 readback code", rd_data, code);
        chk("R3 ce cleared by code write", rd_data[7], 0);
        next_edge(t1);
        next_edge(t2);
        next_edge(t3);
        chk("R6 first span old", t1 - t0, t_old);
        chk("R6 second span new", t2 - t1, t_new);
        chk("R5 steady period", t3 - t2, t_new);
    endtask

    task automatic t_bad_arm();
        int t, p;
        set_code(8'h00);
        sync_edge();
        do_wr(8'h81, t);
        chk("R1 0x81 does not arm", rd_data[7], 0);
        do_wr(8'h03, t);
        chk("R2 locked code write ignored", rd_data, 8'h00);
        period(p);
        chk("R2 period unchanged", p, 1);
    endtask

    task automatic t_window(input int skip, input bit accept);
        int t;
        set_code(8'h00);
        sync_edge();
        do_wr(8'h80, t);
        repeat (skip) sync_edge();
        do_wr(8'h02, t);
        chk(accept ? "R3 write at edge 4 taken" : "R3 write at edge 5 refused",
            rd_data, accept ? 8'h02 : 8'h00);
    endtask

    task automatic t_ce_timeout();
        int t;
        set_code(8'h00);
        sync_edge();
        do_wr(8'h80, t);
        repeat (3) sync_edge();
        chk("R3 ce held after edge 3", rd_data[7], 1);
        sync_edge();
        chk("R3 ce gone after edge 4", rd_data[7], 0);
    endtask

    task automatic t_rearm();
        int t;
        set_code(8'h00);
        sync_edge();
        do_wr(8'h80, t);
        sync_edge();
        do_wr(8'h80, t);
        chk("R4 rearm keeps ce", rd_data[7], 1);
        repeat (2) sync_edge();
        do_wr(8'h04, t);
        chk("R4 window not restarted", rd_data, 8'h00);
    endtask

    task automatic t_ce_plus_bits();
        int t, p;
        set_code(8'h00);
        sync_edge();
        do_wr(8'h80, t);
        do_wr(8'h82, t);
        chk("R2 0x82 ignored", rd_data, 8'h80);
        do_wr(8'h05, t);
        chk("R2 code taken after ignore", rd_data, 8'h05);
        sync_edge();
        period(p);
        chk("R5 div32", p, 32);
    endtask

    task automatic t_reserved();
        int p;
        set_code(8'h01);
        sync_edge(); sync_edge();
        period(p);
        chk("R5 div2", p, 2);
        set_code(8'h0B);
        chk("R5 reserved readback", rd_data, 8'h0B);
        sync_edge();
        period(p);
        chk("R5 reserved code div1", p, 1);
    endtask

    task automatic t_pin();
        clkout_en = 1'b0;
        gpio_out = 1'b1;
        #1;
        chk("R8 pin gpio high", pin_out, 1);
        gpio_out = 1'b0;
        #1;
        chk("R8 pin gpio low", pin_out, 0);
        clkout_en = 1'b1;
        @(posedge src_clk); #0.5;
        chk("R8 pin follows clock", pin_out, sys_clk);
    endtask

    initial begin
        t_reset();
        set_code(8'h00);
        t_switch(8'h02, 1, 4);
        t_switch(8'h08, 4, 256);
        t_switch(8'h00, 256, 1);
        t_bad_arm();
        t_window(3, 1'b1);
        t_window(4, 1'b0);
        t_ce_timeout();
        t_rearm();
        t_ce_plus_bits();
        t_reserved();
        t_pin();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule